// File: doc/BRIEF.md
# Flash Erase Sequencer

This controller sits on the host side of a command-register flash array and runs the complete whole-array erase procedure by itself. After a start pulse it turns on the program-voltage enable and asks a separate byte-program engine to write zeros into every location through a start/done handshake. Only then does it erase. An erase is two back-to-back bus writes of 20h followed by a long settling delay. The controller then checks the array one byte at a time. For each byte it writes the verify command A0h together with the byte address, waits a short delay, reads the byte and compares it with FFh.

When a byte is not yet fully erased, the controller does not restart the scan. It keeps the failing address, increments its erase-attempt count and erases again, then continues verifying from the kept address. A match on the last address ends the run as a pass. A mismatch once the attempt count has reached its limit ends the run as a fail. In both cases the controller writes the read command 00h, drops the voltage enable and pulses done with the result.

The bus is a plain synchronous master with single-cycle write and read strobes. Read data is taken in the cycle after the read strobe. Both delays and the attempt limit are parameters, with the delays given in clock cycles.

Top module: `flash_erase_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released with no start, vpp_en_o, pgm_start_o, bus_wr_o, bus_rd_o and done_o are all 0.
- R2: A start pulse raises vpp_en_o at least one cycle before the first pgm_start_o. vpp_en_o stays 1 on every cycle in which bus_wr_o is 1.
- R3: Exactly one pgm_start_o pulse is issued per run. No bus write occurs until pgm_done_i has been seen.
- R4: An erase is two bus writes of data 20h on consecutive cycles. The next bus write, an A0h verify command, comes ERASE_WAIT+1 cycles after the second 20h write.
- R5: A verify step writes A0h with bus_addr_o set to the byte address. It asserts bus_rd_o with the same address VERIFY_WAIT+1 cycles later and evaluates bus_rdata_i in the following cycle.
- R6: The first verify of a run targets address 0. After a byte reads FFh, the next verify targets the next address. A match at the all-ones address ends the run with pass_o = 1.
- R7: After a mismatch at address A, the controller performs another erase (R4), and the next verify targets A again, not address 0.
- R8: A mismatch when MAX_ERASE erases have already been performed ends the run with pass_o = 0 and no further erase.
- R9: Every run ends with a bus write of 00h. In the next cycle done_o pulses for one cycle with vpp_en_o = 0, and pass_o holds the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | One-cycle request to begin an erase run |
| pgm_start_o | output | 1 | One-cycle request to the byte-program engine to zero the array |
| pgm_done_i | input | 1 | Pre-programming finished |
| vpp_en_o | output | 1 | Program-voltage enable |
| bus_addr_o | output | ADDR_W | Byte address for verify commands and reads |
| bus_wdata_o | output | 8 | Command byte written to the device |
| bus_wr_o | output | 1 | Write strobe, one cycle per command |
| bus_rd_o | output | 1 | Read strobe, one cycle per verify read |
| bus_rdata_i | input | 8 | Read data, valid in the cycle after bus_rd_o |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Result of the last run, 1 = erased |

## Verification
The compare cycle makes two decisions at the same time: whether the scan has reached the all-ones address, and whether the attempt count is at the limit. The bench arranges for both to arrive in one compare by making the last byte need exactly MAX_ERASE erases, which must pass. It also makes the last byte need one erase more than that, which must fail with MAX_ERASE erases and no extra one. A byte at address 0 that needs MAX_ERASE erases covers the same limit at the other end of the scan. In every case the bench judges the erase count and the number of verify reads it observed, so a rescan from address 0 or an off-by-one limit shows up in the counts.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_VPP,
    S_PRE,
    S_PREW,
    S_ER1,
    S_ER2,
    S_EWAIT,
    S_VCMD,
    S_VWAIT,
    S_VRD,
    S_VCMP,
    S_RDCMD,
    S_FIN
  } fe_state_t;

  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_EVERIFY = 8'hA0;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;

endpackage

// File: rtl/fe_timer.sv
// Down-counting delay: loaded with N, run_i active, last_o on the Nth cycle.
module fe_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         last_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == W'(1));

endmodule

// File: rtl/fe_scan.sv
// Verify address pointer and erase-attempt counter.
module fe_scan #(
  parameter int AW = 15,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          addr_inc_i,
  input  logic          ers_inc_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_last_o,
  output logic [CW-1:0] ers_cnt_o
);

  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] ers_q, ers_d;
  logic          addr_en, ers_en;

  always_comb begin
    addr_en = clr_i | addr_inc_i;
    addr_d  = clr_i ? '0 : addr_q + 1'b1;
    ers_en  = clr_i | ers_inc_i;
    ers_d   = clr_i ? '0 : ers_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ers_q  <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (ers_en)  ers_q  <= ers_d;
    end
  end

  assign addr_o      = addr_q;
  assign addr_last_o = &addr_q;
  assign ers_cnt_o   = ers_q;

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int ERASE_WAIT  = 500000,
  parameter int VERIFY_WAIT = 300,
  parameter int MAX_ERASE   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              pgm_start_o,
  input  logic              pgm_done_i,
  output logic              vpp_en_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  input  logic [7:0]        bus_rdata_i,
  output logic              done_o,
  output logic              pass_o
);

  localparam int MAXW = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT;
  localparam int TW   = $clog2(MAXW + 1);
  localparam int CW   = $clog2(MAX_ERASE + 1);

  fe_state_t   state_q, state_d;
  logic        pass_q, pass_d, pass_en;
  logic        tmr_load, tmr_run, tmr_last;
  logic [TW-1:0] tmr_val;
  logic        scan_clr, addr_inc, ers_inc, addr_last;
  logic [CW-1:0] ers_cnt;
  logic        at_limit, byte_ok;

  fe_timer #(.W(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (tmr_run),
    .last_o     (tmr_last)
  );

  fe_scan #(.AW(ADDR_W), .CW(CW)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (scan_clr),
    .addr_inc_i  (addr_inc),
    .ers_inc_i   (ers_inc),
    .addr_o      (bus_addr_o),
    .addr_last_o (addr_last),
    .ers_cnt_o   (ers_cnt)
  );

  assign at_limit = (ers_cnt >= CW'(MAX_ERASE));
  assign byte_ok  = (bus_rdata_i == BYTE_ERASED);

  // Next state and control strobes.
  always_comb begin
    state_d  = state_q;
    pass_d   = pass_q;
    pass_en  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = TW'(VERIFY_WAIT);
    tmr_run  = 1'b0;
    scan_clr = 1'b0;
    addr_inc = 1'b0;
    ers_inc  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d  = S_VPP;
        scan_clr = 1'b1;
        pass_en  = 1'b1;
        pass_d   = 1'b0;
      end
      S_VPP:  state_d = S_PRE;
      S_PRE:  state_d = S_PREW;
      S_PREW: if (pgm_done_i) state_d = S_ER1;
      S_ER1:  state_d = S_ER2;
      S_ER2: begin
        state_d  = S_EWAIT;
        ers_inc  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TW'(ERASE_WAIT);
      end
      S_EWAIT: begin
        tmr_run = 1'b1;
        if (tmr_last) state_d = S_VCMD;
      end
      S_VCMD: begin
        state_d  = S_VWAIT;
        tmr_load = 1'b1;
      end
      S_VWAIT: begin
        tmr_run = 1'b1;
        if (tmr_last) state_d = S_VRD;
      end
      S_VRD:  state_d = S_VCMP;
      S_VCMP: begin
        if (byte_ok) begin
          if (addr_last) begin
            state_d = S_RDCMD;
            pass_en = 1'b1;
            pass_d  = 1'b1;
          end else begin
            state_d  = S_VCMD;
            addr_inc = 1'b1;
          end
        end else if (at_limit) begin
          state_d = S_RDCMD;
        end else begin
          state_d = S_ER1;
        end
      end
      S_RDCMD: state_d = S_FIN;
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pass_en) pass_q <= pass_d;
    end
  end

  // Moore output decode.
  always_comb begin
    vpp_en_o    = (state_q != S_IDLE) && (state_q != S_FIN);
    pgm_start_o = (state_q == S_PRE);
    bus_wr_o    = (state_q == S_ER1) || (state_q == S_ER2) ||
                  (state_q == S_VCMD) || (state_q == S_RDCMD);
    bus_rd_o    = (state_q == S_VRD);
    done_o      = (state_q == S_FIN);
    unique case (state_q)
      S_ER1, S_ER2: bus_wdata_o = CMD_ERASE;
      S_VCMD:       bus_wdata_o = CMD_EVERIFY;
      default:      bus_wdata_o = CMD_READ;
    endcase
  end

  assign pass_o = pass_q;

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vpp_en_o,
  input logic          pgm_start_o,
  input logic          bus_wr_o,
  input logic          bus_rd_o,
  input logic [7:0]    bus_wdata_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          done_o
);

  a_r1_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_start_o, bus_wr_o, bus_rd_o, done_o}));

  a_r2_write_has_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_o |-> vpp_en_o);

  a_r2_vpp_before_pgm: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start_o |-> $past(vpp_en_o));

  a_r4_erase_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && bus_wdata_o == 8'h20 && !$past(bus_wr_o && bus_wdata_o == 8'h20))
      |=> (bus_wr_o && bus_wdata_o == 8'h20));

  a_r5_read_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_o |-> ($stable(bus_addr_o) && !$past(bus_wr_o)));

  a_r9_done_vpp_off: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !vpp_en_o);

  a_r9_read_cmd_first: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(bus_wr_o) && $past(bus_wdata_o) == 8'h00));

endmodule

bind flash_erase_seq flash_erase_seq_chk #(.AW(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vpp_en_o    (vpp_en_o),
  .pgm_start_o (pgm_start_o),
  .bus_wr_o    (bus_wr_o),
  .bus_rd_o    (bus_rd_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_addr_o  (bus_addr_o),
  .done_o      (done_o)
);

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int EW    = 10;
  localparam int VW    = 6;
  localparam int MAXE  = 4;

  // Scenario table: two slow bytes (address, erases needed) and expected results.
  localparam int NSC = 8;
  localparam int T_A1 [NSC] = '{0, 5, 3, 0, 15, 15, 7, 15};
  localparam int T_N1 [NSC] = '{1, 2, 2, 4, 5, 2, 6, 4};
  localparam int T_A2 [NSC] = '{0, 5, 9, 0, 15, 15, 7, 15};
  localparam int T_N2 [NSC] = '{1, 2, 3, 4, 5, 2, 6, 4};
  localparam int T_PASS[NSC] = '{1, 1, 1, 1, 0, 1, 0, 1};
  localparam int T_ERS [NSC] = '{1, 2, 3, 4, 4, 2, 4, 4};
  localparam int T_RDS [NSC] = '{16, 17, 18, 19, 19, 17, 11, 19};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          pgm_done_i = 1'b0;
  logic [7:0]    bus_rdata_i = 8'h00;
  logic          pgm_start_o, vpp_en_o, bus_wr_o, bus_rd_o, done_o, pass_o;
  logic [AW-1:0] bus_addr_o;
  logic [7:0]    bus_wdata_o;

  int n_chk = 0;
  int n_fail = 0;
  int wd_cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_seq #(
    .ADDR_W(AW), .ERASE_WAIT(EW), .VERIFY_WAIT(VW), .MAX_ERASE(MAXE)
  ) u_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .pgm_start_o(pgm_start_o), .pgm_done_i(pgm_done_i), .vpp_en_o(vpp_en_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_wr_o(bus_wr_o),
    .bus_rd_o(bus_rd_o), .bus_rdata_i(bus_rdata_i), .done_o(done_o), .pass_o(pass_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd_cyc++;
    if (wd_cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", wd_cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_case(input int idx);
    int need[DEPTH];
    int ers = 0, reads = 0, pre = 0, cyc = 0, pgm_cd = 0;
    int e2 = -1, a0c = 0, a0addr = 0, expa = 0;
    int err2 = 0, err3 = 0, err4 = 0, err5 = 0, err67 = 0, err9 = 0;
    bit pre_ok = 0, pair = 0, jerase = 0, fin = 0, prev_vpp = 0;
    bit prev_rd_cmd = 0;
    for (int i = 0; i < DEPTH; i++) need[i] = 1;
    need[T_A1[idx]] = T_N1[idx];
    need[T_A2[idx]] = T_N2[idx];

    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    prev_vpp = vpp_en_o;
    while (!fin && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      pgm_done_i = 1'b0;
      if (pgm_cd > 0) begin
        pgm_cd--;
        if (pgm_cd == 0) begin pgm_done_i = 1'b1; pre_ok = 1; end
      end
      if (pgm_start_o) begin
        pre++;
        if (!prev_vpp) err2++;
        pgm_cd = 3;
      end
      if (bus_wr_o) begin
        if (!vpp_en_o) err2++;
        if (!pre_ok) err3++;
        if (pair && bus_wdata_o != 8'h20) err4++;
        if (bus_wdata_o == 8'h20) begin
          if (pair) begin ers++; e2 = cyc; jerase = 1; pair = 0; end
          else pair = 1;
        end else if (bus_wdata_o == 8'hA0) begin
          if (jerase && (cyc - e2) != EW + 1) err4++;
          jerase = 0;
          if (int'(bus_addr_o) != expa) err67++;
          a0c = cyc; a0addr = int'(bus_addr_o);
        end
      end else if (pair) begin
        err4++;
        pair = 0;
      end
      if (bus_rd_o) begin
        reads++;
        if ((cyc - a0c) != VW + 1 || int'(bus_addr_o) != a0addr) err5++;
        if (ers >= need[bus_addr_o]) begin
          bus_rdata_i = 8'hFF;
          expa = int'(bus_addr_o) + 1;
        end else bus_rdata_i = 8'h7F;
      end
      if (done_o) begin
        fin = 1;
        if (vpp_en_o || !prev_rd_cmd) err9++;
        check(pass_o == T_PASS[idx][0], "R6/R8 result", int'(pass_o), T_PASS[idx]);
      end
      prev_rd_cmd = bus_wr_o && bus_wdata_o == 8'h00;
      prev_vpp = vpp_en_o;
    end
    check(fin, "R9 run ends", int'(fin), 1);
    check(err2 == 0, "R2 voltage enable", err2, 0);
    check(err3 == 0 && pre == 1, "R3 pre-program", pre, 1);
    check(err4 == 0, "R4 erase pair and wait", err4, 0);
    check(err5 == 0, "R5 verify timing", err5, 0);
    check(err67 == 0, "R6/R7 verify address order", err67, 0);
    check(ers == T_ERS[idx], "R7/R8 erase count", ers, T_ERS[idx]);
    check(reads == T_RDS[idx], "R7 resume read count", reads, T_RDS[idx]);
    check(err9 == 0, "R9 read command then done", err9, 0);
    @(negedge clk);
    check(!done_o && !vpp_en_o, "R9 done is a pulse", int'(done_o), 0);
    check(pass_o == T_PASS[idx][0], "R9 result held", int'(pass_o), T_PASS[idx]);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check({vpp_en_o, pgm_start_o, bus_wr_o, bus_rd_o, done_o} == 5'b0, "R1 in reset",
          int'({vpp_en_o, pgm_start_o, bus_wr_o, bus_rd_o, done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({vpp_en_o, pgm_start_o, bus_wr_o, bus_rd_o, done_o} == 5'b0, "R1 after release",
          int'({vpp_en_o, pgm_start_o, bus_wr_o, bus_rd_o, done_o}), 0);

    // Abort a run stuck waiting for pre-programming.
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (10) @(negedge clk);
    check(vpp_en_o && !bus_wr_o, "R3 waits for pgm_done with R2 enable",
          int'({vpp_en_o, bus_wr_o}), 2);
    rst_n = 1'b0;
    @(negedge clk);
    check({vpp_en_o, pgm_start_o, bus_wr_o, bus_rd_o, done_o} == 5'b0, "R1 reset mid-run",
          int'({vpp_en_o, pgm_start_o, bus_wr_o, bus_rd_o, done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < NSC; s++) begin
      run_case(s);
      repeat (3) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule